// File: doc/BRIEF.md
# Shared Timer Prescaler with Per-Channel Clock Select

This block produces the count-enable strobes for two timer channels. Both channels share one free-running 10-bit division counter. Each channel has its own 3-bit select field. The field decides whether the channel stays idle or advances on every system clock. It can also follow one of four division taps (/8, /64, /256, /1024), or follow the rising or falling edges of its own external clock pin. Each enable output is high for one system clock and tells the timer to advance by one.

The division counter does not depend on either select field. A channel that switches to a divided source therefore waits up to one full division period for its first strobe. A synchronous clear strobe restarts the division period, and it does so for both channels together. The external pins are first sampled in the low phase of the system clock and then registered on the rising edge. An edge detector compares the synchronized value with its value one cycle earlier.

Top module: `shared_prescaler_cs`

## Requirements
- R1: While `rst_n` is low, both enable outputs are 0 and the division counter is held at zero.
- R2: Select code 0 keeps the channel's enable output at 0.
- R3: Select code 1 drives the enable output high on every clock edge while the code is held.
- R4: Select codes 2, 3, 4 and 5 give single-cycle enable pulses spaced exactly 8, 64, 256 and 1024 clocks apart.
- R5: After a channel switches from code 0 to a divided code with divisor N, its first enable pulse comes 1 to N+1 clocks later.
- R6: Both channels use the same counter state. When both select the same divisor, their enable outputs are identical on every cycle.
- R7: When the clear strobe is sampled high at clock edge E, no tap fires until edge E+N. At that edge every channel on divisor N pulses. This holds for both channels at once.
- R8: Select code 7 gives exactly one single-cycle enable pulse for each rising edge of the channel's pin. The pulse comes 2 to 3 clocks after the pin change, and falling edges give no pulse.
- R9: Select code 6 gives exactly one single-cycle enable pulse for each falling edge of the pin, with the same 2 to 3 clock delay. Rising edges give no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psc_clr | input | 1 | Synchronous prescaler restart strobe |
| cs0_sel | input | 3 | Channel 0 source select code |
| cs1_sel | input | 3 | Channel 1 source select code |
| xclk0 | input | 1 | Channel 0 external clock pin |
| xclk1 | input | 1 | Channel 1 external clock pin |
| cnt_en0 | output | 1 | Channel 0 count-enable strobe |
| cnt_en1 | output | 1 | Channel 1 count-enable strobe |

## Verification
Each enable output is registered. The output after an edge therefore reflects the select code and the tap state that were present just before that edge. A divided pulse appears one edge after the counter's low bits reach all-ones, which is N edges after a clear. A pin change made during the high phase of the clock reaches the output two edges later. The bench drives inputs 2 ns after each rising edge and samples 1 ns after it. A behavioural reference that uses integer phase and pin history predicts both outputs on every edge. Directed counts of edges check the latency windows, the gaps and the timing after a clear.

// File: rtl/psc_cs_pkg.sv
package psc_cs_pkg;

  localparam int SEL_W    = 3;
  localparam int CNT_W    = 10;
  localparam int NUM_TAPS = 4;
  localparam int NUM_CH   = 2;

  typedef enum logic [SEL_W-1:0] {
    CS_OFF   = 3'd0,
    CS_SYS   = 3'd1,
    CS_D8    = 3'd2,
    CS_D64   = 3'd3,
    CS_D256  = 3'd4,
    CS_D1024 = 3'd5,
    CS_XFALL = 3'd6,
    CS_XRISE = 3'd7
  } cs_code_e;

  // log2 of the division ratio of tap idx
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // division ratio for a select code; 1 for direct, 0 when not counter-driven
  function automatic int sel_divisor(input logic [SEL_W-1:0] code);
    if (code == CS_SYS) return 1;
    if (code >= CS_D8 && code <= CS_D1024) return 1 << tap_log2(int'(code) - 2);
    return 0;
  endfunction

endpackage

// File: rtl/psc_divider.sv
module psc_divider
  import psc_cs_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NT = NUM_TAPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [NT-1:0] tap_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  // each tap fires in the cycle its low bits are all ones (just before wrap)
  for (genvar t = 0; t < NT; t++) begin : g_tap
    localparam int LW = tap_log2(t);
    assign tap_o[t] = &cnt_q[LW-1:0];
  end

  // R4
  tap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o[0] |=> !tap_o[0]);

  // R7
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tap_o == '0));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_o[NT-1] && !clr) |=> (cnt_q == '0));

endmodule

// File: rtl/ext_edge_sync.sv
module ext_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic lat_q, sync_q, prev_q;

  // low-phase capture: holds what the pin showed at the end of the high phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= lat_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R9
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/chan_select.sv
module chan_select
  import psc_cs_pkg::*;
#(
  parameter int NT = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NT-1:0]    tap_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             ce_o
);

  logic ce_nxt, ce_q;

  always_comb begin
    ce_nxt = 1'b0;
    case (sel_i)
      CS_OFF:   ce_nxt = 1'b0;
      CS_SYS:   ce_nxt = 1'b1;
      CS_XFALL: ce_nxt = fall_i;
      CS_XRISE: ce_nxt = rise_i;
      default: begin
        for (int t = 0; t < NT; t++)
          if (sel_i == SEL_W'(t + 2)) ce_nxt = tap_i[t];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b0;
    else        ce_q <= ce_nxt;
  end

  assign ce_o = ce_q;

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CS_OFF) |=> !ce_o);

  // R3
  sys_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CS_SYS) |=> ce_o);

  // R8
  rise_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CS_XRISE && rise_i) |=> ce_o);

  // R9
  fall_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CS_XFALL && !fall_i) |=> !ce_o);

endmodule

// File: rtl/shared_prescaler_cs.sv
module shared_prescaler_cs
  import psc_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psc_clr,
  input  logic [SEL_W-1:0] cs0_sel,
  input  logic [SEL_W-1:0] cs1_sel,
  input  logic             xclk0,
  input  logic             xclk1,
  output logic             cnt_en0,
  output logic             cnt_en1
);

  logic [NUM_TAPS-1:0] tap_w;
  logic [SEL_W-1:0]    sel_arr [NUM_CH];
  logic [NUM_CH-1:0]   pin_arr, rise_arr, fall_arr, ce_arr;

  assign sel_arr[0] = cs0_sel;
  assign sel_arr[1] = cs1_sel;
  assign pin_arr    = {xclk1, xclk0};
  assign cnt_en0    = ce_arr[0];
  assign cnt_en1    = ce_arr[1];

  psc_divider #(.CW(CNT_W), .NT(NUM_TAPS)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (psc_clr),
    .tap_o (tap_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ext_edge_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_arr[c]),
      .rise_o (rise_arr[c]),
      .fall_o (fall_arr[c])
    );

    chan_select #(.NT(NUM_TAPS)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (sel_arr[c]),
      .tap_i  (tap_w),
      .rise_i (rise_arr[c]),
      .fall_i (fall_arr[c]),
      .ce_o   (ce_arr[c])
    );
  end

  // R6
  shared_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_sel == cs1_sel && cs0_sel >= CS_D8 && cs0_sel <= CS_D1024)
      |=> (cnt_en0 == cnt_en1));

endmodule

// File: tb/tb_shared_prescaler_cs.sv
module tb_shared_prescaler_cs;
  import psc_cs_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psc_clr = 1'b0;
  logic [2:0] cs0_sel = 3'd0, cs1_sel = 3'd0;
  logic xclk0 = 1'b0, xclk1 = 1'b0;
  logic cnt_en0, cnt_en1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shared_prescaler_cs dut (
    .clk(clk), .rst_n(rst_n), .psc_clr(psc_clr),
    .cs0_sel(cs0_sel), .cs1_sel(cs1_sel),
    .xclk0(xclk0), .xclk1(xclk1),
    .cnt_en0(cnt_en0), .cnt_en1(cnt_en1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6: return "R9";
      3'd7: return "R8";
      default: return "R4";
    endcase
  endfunction

  // behavioural reference: phase since last clear, two-deep pin history
  int phase = 0;
  int hist1 [2] = '{0, 0};
  int hist2 [2] = '{0, 0};

  function automatic int ref_en(input logic [2:0] s, input int ph, input int h1, input int h2);
    int n;
    case (s)
      3'd0: return 0;
      3'd1: return 1;
      3'd6: return (h1 == 0 && h2 == 1) ? 1 : 0;
      3'd7: return (h1 == 1 && h2 == 0) ? 1 : 0;
      default: begin
        n = sel_divisor(s);
        return ((ph % n) == n - 1) ? 1 : 0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    if (!done) begin
      if (!rst_n) begin
        check(cnt_en0 == 1'b0, "R1", int'(cnt_en0), 0);
        check(cnt_en1 == 1'b0, "R1", int'(cnt_en1), 0);
        phase = 0;
        hist1 = '{0, 0};
        hist2 = '{0, 0};
      end else begin
        int e0, e1;
        e0 = ref_en(cs0_sel, phase, hist1[0], hist2[0]);
        e1 = ref_en(cs1_sel, phase, hist1[1], hist2[1]);
        check(int'(cnt_en0) == e0, req_of(cs0_sel), int'(cnt_en0), e0);
        check(int'(cnt_en1) == e1, req_of(cs1_sel), int'(cnt_en1), e1);
        phase = psc_clr ? 0 : (phase + 1) % 1024;
        hist2 = hist1;
        hist1[0] = int'(xclk0);
        hist1[1] = int'(xclk1);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // edges from now until channel-0 pulses (returns at drive time)
  task automatic wait_pulse0(input int limit, output int k);
    k = 0;
    do begin
      @(posedge clk);
      #1;
      k++;
    end while (!cnt_en0 && k < limit);
    #1;
  endtask

  initial begin
    int lat, gap, k0, k1, cnt;
    repeat (3) @(posedge clk);
    #1;
    check(cnt_en0 == 0 && cnt_en1 == 0, "R1", int'({cnt_en1, cnt_en0}), 0);
    #1;
    rst_n = 1'b1;

    // R2: idle channels stay quiet
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (cnt_en0 || cnt_en1) cnt++;
    end
    #1;
    check(cnt == 0, "R2", cnt, 0);

    // R3: direct clock
    cs0_sel = 3'd1;
    step();
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (cnt_en0) cnt++;
    end
    #1;
    check(cnt == 10, "R3", cnt, 10);
    cs0_sel = 3'd0;
    repeat (3) step();

    // R4 / R5 / R6 for every divisor at two phases
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 2; p++) begin
        int n;
        n = 1 << tap_log2(d);
        repeat (d * 7 + p * 3 + 2) step();
        cs0_sel = 3'(d + 2);
        cs1_sel = 3'(d + 2);
        wait_pulse0(n + 5, lat);
        check(lat >= 1 && lat <= n + 1, "R5", lat, n);
        cnt = 0;
        gap = 0;
        do begin
          @(posedge clk); #1;
          gap++;
          if (cnt_en0 != cnt_en1) cnt++;
        end while (!cnt_en0 && gap < n + 5);
        #1;
        check(gap == n, "R4", gap, n);
        check(cnt == 0, "R6", cnt, 0);
        cs0_sel = 3'd0;
        cs1_sel = 3'd0;
        step();
      end
    end

    // R7: clear restarts both channels together
    cs0_sel = 3'd2;
    cs1_sel = 3'd3;
    repeat (37) step();
    psc_clr = 1'b1;
    @(posedge clk);
    #2;
    psc_clr = 1'b0;
    k0 = 0;
    k1 = 0;
    for (int k = 1; k <= 70; k++) begin
      @(posedge clk); #1;
      if (cnt_en0 && k0 == 0) k0 = k;
      if (cnt_en1 && k1 == 0) k1 = k;
    end
    #1;
    check(k0 == 8, "R7", k0, 8);
    check(k1 == 64, "R7", k1, 64);
    cs0_sel = 3'd0;
    cs1_sel = 3'd0;
    step();

    // R8: rising-edge select
    cs0_sel = 3'd7;
    repeat (3) step();
    xclk0 = 1'b1;
    wait_pulse0(6, lat);
    check(lat == 2, "R8", lat, 2);
    cnt = 0;
    repeat (4) step();
    xclk0 = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (cnt_en0) cnt++;
    end
    #1;
    check(cnt == 0, "R8", cnt, 0);

    // R9: falling-edge select on channel 1
    cs1_sel = 3'd6;
    xclk1 = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (cnt_en1) cnt++;
    end
    #1;
    check(cnt == 0, "R9", cnt, 0);
    xclk1 = 1'b0;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (cnt_en1) cnt++;
    end
    #1;
    check(cnt == 1, "R9", cnt, 1);

    repeat (3) step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule